// File: doc/BRIEF.md
# Clocked Processor Bus Slave with Ready Handshake

This block is a bus slave for an embedded processor that runs a synchronous bus. Every input is sampled on the rising edge of the bus clock. An access opens when the slave samples its chip select and its active-low data strobe both low. A single direction line gives the kind of access: low is a write and high is a read. The address is 15 bits wide and the data path is 8 bits wide. The slave ends each access by raising a ready pulse, and then waits until the processor lets go of the strobe.

Behind the bus logic sits a plain register-file port with address, write data, write enable, read enable and read data. A small array of registers backs this port so the bus side can be tested. The data bus is bidirectional, and it appears at the top as three signals: an input half, an output half and an output-enable that controls the tristate buffer outside the block. The bus carries no streaming data, so every pin is a plain control or data pin and there is no valid/ready back-pressure. The ready output only marks the end of an access.

Top module: `mpb_slave`

## Requirements
- R1: After reset, ready (`rdy`) is low, the output enable (`d_oe`) is low, and every implemented register reads as zero.
- R2: When the slave is idle and samples `cs_n` = 0 and `strb_n` = 0 at a clock edge, it accepts an access. `rdy` is high during the bus clock that follows that edge.
- R3: When `rw` = 0 at the accepting edge, the value on `d_in` at that edge is stored in the register at `addr`, and a later read returns it.
- R4: When `rw` = 1 at the accepting edge, `d_oe` is high and `d_out` holds the addressed register's value from the cycle after that edge through the cycle in which `strb_n` = 1 is sampled. `d_oe` is low again in the cycle after that.
- R5: `rdy` is high for exactly one cycle per access. While `strb_n` stays low after the accepting edge, no further access is accepted and `rdy` stays low.
- R6: A strobe sampled while `cs_n` = 1 is ignored: `rdy` stays low, `d_oe` stays low and no register changes.
- R7: An address at or above the number of implemented registers reads as zero and ignores writes, and it still returns the one-cycle `rdy` pulse.
- R8: Address decode uses all 15 address bits. An address whose low bits match a register but whose upper bits are set (for example 0x4003) is out of range and does not alias that register.
- R9: Write data is taken only at the accepting edge. Changes on `d_in` after that edge do not alter the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | Access direction: 1 = read, 0 = write |
| strb_n | input | 1 | Active-low data strobe that opens an access |
| addr | input | 15 | Target address |
| d_in | input | 8 | Input half of the data bus |
| d_out | output | 8 | Output half of the data bus (zero when not driving) |
| d_oe | output | 1 | Enable for the external tristate data driver |
| rdy | output | 1 | One-cycle ready pulse that ends an access |

## Verification
The bench builds the slave with a 15-bit address, an 8-bit data path and 8 implemented registers. With only eight registers, address 8 sits just past the end of the array. The address 0x4003 shares its low bits with register 3, so the bench can test both the range edge and upper-bit aliasing with only a few accesses. The bench also covers several strobe hold lengths, from release on the cycle after acceptance to several extra cycles. These show that there is one ready pulse per access and that the read drive window is correct.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  // Access phases of the bus slave
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for chip select and strobe
    ST_RESP = 2'd1,  // ready cycle, register port active
    ST_HOLD = 2'd2   // waiting for the strobe to be released
  } mpb_state_e;

endpackage

// File: rtl/mpb_regfile.sv
module mpb_regfile #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_wdata,
  input  logic              rf_we,
  input  logic              rf_re,
  output logic [DATA_W-1:0] rf_rdata
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem;
  logic                            in_range;
  logic [IDX_W-1:0]                idx;

  // Compare the whole address so that set upper bits never alias a register
  assign in_range = (rf_addr < LIMIT);
  assign idx      = rf_addr[IDX_W-1:0];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic hit;
    assign hit = rf_we && in_range && (idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[gi] <= '0;
      else if (hit) mem[gi] <= rf_wdata;
    end
  end

  always_comb begin
    rf_rdata = '0;
    if (rf_re && in_range) rf_rdata = mem[idx];
  end

  // Writes to unimplemented addresses leave the array untouched
  assert_oor_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !in_range) |=> $stable(mem));

endmodule

// File: rtl/mpb_ctrl.sv
module mpb_ctrl
  import mpb_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              strb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output logic              rdy,
  output logic              d_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re
);

  mpb_state_e        state;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_data;
  logic              acc_rd;
  logic              start;

  assign start = (state == ST_IDLE) && !cs_n && !strb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      acc_addr <= '0;
      acc_data <= '0;
      acc_rd   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          acc_addr <= addr;
          acc_data <= d_in;
          acc_rd   <= rw;
          state    <= ST_RESP;
        end
        ST_RESP: state <= strb_n ? ST_IDLE : ST_HOLD;
        ST_HOLD: if (strb_n) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rdy      = (state == ST_RESP);
  assign rf_addr  = acc_addr;
  assign rf_wdata = acc_data;
  assign rf_we    = (state == ST_RESP) && !acc_rd;
  assign rf_re    = (state != ST_IDLE) && acc_rd;
  assign d_oe     = rf_re;

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !cs_n && !strb_n) |=> rdy);

  assert_rdy_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  assert_cs_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && cs_n) |=> (!rdy && !d_oe));

  assert_oe_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && !strb_n) |=> d_oe);

endmodule

// File: rtl/mpb_slave.sv
module mpb_slave #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              strb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  output logic              rdy
);

  logic [ADDR_W-1:0] rf_addr;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] rf_rdata;
  logic              rf_we;
  logic              rf_re;

  mpb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .strb_n(strb_n),
    .addr(addr), .d_in(d_in), .rdy(rdy), .d_oe(d_oe),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re)
  );

  mpb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  assign d_out = d_oe ? rf_rdata : '0;

  // While a read keeps the bus, the driven value does not move
  assert_read_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && $past(d_oe)) |-> $stable(d_out));

endmodule

// File: tb/mpb_slave_bench.sv
module mpb_slave_bench;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          rw = 1'b1;
  logic          strb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic          d_oe;
  logic          rdy;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mpb_slave #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) u_mpb_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .strb_n(strb_n),
    .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Write access: strobe held for 'hold' extra cycles after the ready cycle
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v, input int hold);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = a; d_in = v; strb_n = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b1, "R2 write ready", int'(rdy), 1);
    chk(d_oe == 1'b0, "R3 no drive on write", int'(d_oe), 0);
    d_in = ~v;  // R9: later data must not be stored
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rdy == 1'b0, "R5 single ready", int'(rdy), 0);
    end
    strb_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b0, "R5 ready after release", int'(rdy), 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input int hold, input string req);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; addr = a; strb_n = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b1, "R2 read ready", int'(rdy), 1);
    chk(d_oe == 1'b1, "R4 drive on", int'(d_oe), 1);
    chk(d_out == exp, req, int'(d_out), int'(exp));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rdy == 1'b0, "R5 no second ready", int'(rdy), 0);
      chk(d_oe == 1'b1 && d_out == exp, "R4 held drive", int'(d_out), int'(exp));
    end
    strb_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk(d_oe == 1'b0, "R4 drive off", int'(d_oe), 0);
  endtask

  task automatic t_reset();
    chk(rdy == 1'b0, "R1 rdy in reset", int'(rdy), 0);
    chk(d_oe == 1'b0, "R1 oe in reset", int'(d_oe), 0);
    for (int r = 0; r < NR; r++) do_read(AW'(r), 8'h00, 0, "R1 reset value");
  endtask

  task automatic t_write_read();
    do_write(15'd1, 8'hA5, 0);
    do_write(15'd6, 8'h3C, 3);
    do_read(15'd1, 8'hA5, 0, "R3 readback reg1 (R9 late data)");
    do_read(15'd6, 8'h3C, 4, "R4 held read reg6");
  endtask

  task automatic t_cs_ignored();
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b0; addr = 15'd1; d_in = 8'h5A; strb_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rdy == 1'b0 && d_oe == 1'b0, "R6 no response", int'({rdy, d_oe}), 0);
    end
    strb_n = 1'b1;
    do_read(15'd1, 8'hA5, 0, "R6 register unchanged");
  endtask

  task automatic t_out_of_range();
    do_write(15'd8, 8'hFF, 1);
    do_read(15'd8, 8'h00, 0, "R7 oor reads zero");
    do_read(15'd0, 8'h00, 0, "R7 reg0 untouched");
    do_write(15'h4003, 8'h77, 0);
    do_read(15'd3, 8'h00, 0, "R8 no alias into reg3");
    do_read(15'h4003, 8'h00, 2, "R8 high address reads zero");
  endtask

  task automatic t_pattern();
    for (int r = 0; r < NR; r++) do_write(AW'(r), DW'(8'h11 * r + 8'h0F), r % 3);
    for (int r = 0; r < NR; r++) do_read(AW'(r), DW'(8'h11 * r + 8'h0F), 1, "R3 pattern");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_cs_ignored();
    t_out_of_range();
    t_pattern();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic t_reset_pre();
    chk(rdy == 1'b0 && d_oe == 1'b0, "R1 outputs held in reset", int'({rdy, d_oe}), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule